// File: doc/BRIEF.md
# I2C Segment Launch Register Front-End

This block is the processor-facing half of an I2C controller. Software programs a target address byte, a byte count, a transfer direction, condition flags and up to eight data words through a small word-addressed register space. It then writes the go bit to hand one transfer segment to a bit-level bus sequencer. The sequencer sits behind a plain command interface. It receives a one-cycle start pulse and the segment parameters, fetches transmit bytes by index, returns received bytes by index, and ends the segment with a done pulse that carries an acknowledge-missing flag.

Each data word holds either one byte or four bytes, selected by a mode bit. The count field narrows to 4 bits in the one-byte mode and widens to 6 bits in the four-byte mode. Bytes sit little-endian inside a word in both the transmit and the receive banks. When the segment finishes, a completion status bit is set and an interrupt line follows it if enabled. Writing zero to the launch/status register returns the block to idle.

Word map (index on `bus_addr`): 0 target address, 1 count, 2 control, 3 mode control, 4 launch/status, 8..15 transmit words, 16..23 receive words (read-only).

Top module: `i2cf_seg_front`

## Requirements
- R1: After reset every control, count, address and launch/status register reads as zero, `irq` is 0 and `seq_start` is 0.
- R2: With mode bit 6 of word 3 set (four-byte mode), sequencer byte index i reads byte lane i%4 (bits 8*(i%4)+7 : 8*(i%4)) of transmit word i/4.
- R3: With mode bit 6 of word 3 clear (one-byte mode), byte index i reads bits 7:0 of transmit word i for i < 8, and index 8 or above reads 0x00.
- R4: Word 1 reads back the written count masked to 6 bits in four-byte mode and to 4 bits in one-byte mode; `seq_len` equals that masked count limited to 32 (four-byte) or 8 (one-byte).
- R5: A write to word 4 with bit 0 set while idle gives a one-cycle `seq_start` on the next cycle, sets the busy bit (bit 0), latches bits 6:4 to `seq_cond`, and clears old completion and NOACK status; `seq_dir` carries control bits 1:0 (0 write, 1 read, 2 read-then-write, 3 write-then-read).
- R6: While busy, a nonzero write to word 4 has no effect: no new `seq_start` and the register keeps its value.
- R7: A `seq_done` pulse while busy clears busy and sets the completion bit (bit 1); a `seq_done` while idle is ignored; `irq` is high exactly when completion is set and control bit 6 is set.
- R8: At completion, bit 2 of word 4 records `seq_nack`, unless bit 1 of word 3 (ignore acknowledge) is set, in which case it stays 0.
- R9: Writing zero to word 4 clears busy, completion, NOACK and the condition flags, and wins over a `seq_done` in the same cycle.
- R10: A `seq_rx_valid` byte while busy lands in receive word and lane by the same mapping as R2/R3; bytes with an out-of-range index, or that arrive while idle, are dropped.
- R11: Bus writes to the receive words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd_en` |
| irq | output | 1 | Completion interrupt |
| seq_start | output | 1 | One-cycle segment start to the sequencer |
| seq_dir | output | 2 | Transfer direction code |
| seq_cond | output | 3 | Condition flags {repeated start, no start, no stop} |
| seq_len | output | 6 | Segment byte count after masking and limiting |
| seq_addr | output | 8 | Target address byte |
| seq_ign_nack | output | 1 | Ignore missing acknowledge |
| seq_tx_idx | input | 5 | Transmit byte index requested by the sequencer |
| seq_tx_byte | output | 8 | Transmit byte for `seq_tx_idx` |
| seq_rx_valid | input | 1 | Received byte strobe |
| seq_rx_idx | input | 5 | Received byte index |
| seq_rx_byte | input | 8 | Received byte value |
| seq_done | input | 1 | Segment finished pulse |
| seq_nack | input | 1 | Acknowledge missing, qualified by `seq_done` |

## Verification
The sequencer's completion pulse and a software write of zero to the launch/status register can land on the same clock edge. That collision decides whether completion status survives an abort. The bench launches a segment, then drives `seq_done` with `seq_nack` and the zero write in one cycle. It expects the register to read zero and `irq` to stay low afterwards. A second overlap, a go write while a segment is still running, is judged by the absence of a new start pulse and an unchanged readback.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  typedef enum logic [1:0] {
    DIR_WRITE    = 2'd0,
    DIR_READ     = 2'd1,
    DIR_RD_THEN_WR = 2'd2,
    DIR_WR_THEN_RD = 2'd3
  } i2cf_dir_e;

  // word indices of the fixed registers
  localparam int unsigned W_TADDR = 0;
  localparam int unsigned W_COUNT = 1;
  localparam int unsigned W_CTRL  = 2;
  localparam int unsigned W_MODE  = 3;
  localparam int unsigned W_XFER  = 4;

  // bit positions
  localparam int unsigned CTRL_IRQEN  = 6;
  localparam int unsigned MODE_WIDE   = 6;
  localparam int unsigned MODE_IGNACK = 1;
  localparam int unsigned XS_GO       = 0;
  localparam int unsigned XS_DONE     = 1;
  localparam int unsigned XS_NACK     = 2;
  localparam int unsigned XS_COND_LSB = 4;

  localparam int unsigned BYTES_PER_WORD = 4;
endpackage

// File: rtl/i2cf_lane_map.sv
module i2cf_lane_map #(
  parameter int unsigned NUM_DREGS = 8,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned RIDX_W    = 3
) (
  input  logic              wide,
  input  logic [IDX_W-1:0]  idx,
  output logic [RIDX_W-1:0] sel,
  output logic [1:0]        lane,
  output logic              in_range
);
  localparam logic [IDX_W-1:0] NARROW_LIM = IDX_W'(NUM_DREGS);

  always_comb begin
    if (wide) begin
      sel      = idx[IDX_W-1:2];
      lane     = idx[1:0];
      in_range = 1'b1;
    end else begin
      sel      = idx[RIDX_W-1:0];
      lane     = 2'd0;
      in_range = (idx < NARROW_LIM);
    end
  end
endmodule

// File: rtl/i2cf_data_bank.sv
module i2cf_data_bank #(
  parameter int unsigned NUM_DREGS = 8,
  parameter int unsigned RIDX_W    = 3
) (
  input  logic              clk,
  input  logic              tx_we,
  input  logic [RIDX_W-1:0] tx_wsel,
  input  logic [31:0]       tx_wdata,
  input  logic              rx_we,
  input  logic [RIDX_W-1:0] rx_sel,
  input  logic [1:0]        rx_lane,
  input  logic [7:0]        rx_byte,
  input  logic [RIDX_W-1:0] tx_rsel,
  input  logic [1:0]        tx_lane,
  input  logic [RIDX_W-1:0] rd_sel,
  output logic [7:0]        tx_byte,
  output logic [31:0]       tx_word,
  output logic [31:0]       rx_word
);
  logic [31:0] tx_mem [NUM_DREGS];
  logic [31:0] rx_mem [NUM_DREGS];

  always_ff @(posedge clk) begin
    if (tx_we) tx_mem[tx_wsel] <= tx_wdata;
  end

  always_ff @(posedge clk) begin
    if (rx_we) rx_mem[rx_sel][{rx_lane, 3'b000} +: 8] <= rx_byte;
  end

  assign tx_byte = tx_mem[tx_rsel][{tx_lane, 3'b000} +: 8];
  assign tx_word = tx_mem[rd_sel];
  assign rx_word = rx_mem[rd_sel];
endmodule

// File: rtl/i2cf_xfer_ctrl.sv
module i2cf_xfer_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_xfer,
  input  logic       wr_zero,
  input  logic [6:0] wval,
  input  logic       seq_done,
  input  logic       seq_nack,
  input  logic       ign_nack,
  output logic       busy_o,
  output logic       done_o,
  output logic       nack_o,
  output logic       start_o,
  output logic [2:0] cond_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      nack_o  <= 1'b0;
      start_o <= 1'b0;
      cond_o  <= 3'd0;
    end else begin
      start_o <= 1'b0;
      if (wr_xfer && wr_zero) begin
        // abort / acknowledge: beats a completion in the same cycle
        busy_o <= 1'b0;
        done_o <= 1'b0;
        nack_o <= 1'b0;
        cond_o <= 3'd0;
      end else if (!busy_o) begin
        if (wr_xfer) begin
          cond_o <= wval[6:4];
          if (wval[0]) begin
            busy_o  <= 1'b1;
            start_o <= 1'b1;
            done_o  <= 1'b0;
            nack_o  <= 1'b0;
          end
        end
      end else if (seq_done) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        nack_o <= seq_nack & ~ign_nack;
      end
    end
  end
endmodule

// File: rtl/i2cf_seg_front.sv
module i2cf_seg_front #(
  parameter int unsigned NUM_DREGS = 8,
  parameter int unsigned ADDR_W    = $clog2(3 * NUM_DREGS),
  parameter int unsigned LEN_W     = $clog2(NUM_DREGS * 4) + 1,
  parameter int unsigned IDX_W     = $clog2(NUM_DREGS * 4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              seq_start,
  output logic [1:0]        seq_dir,
  output logic [2:0]        seq_cond,
  output logic [LEN_W-1:0]  seq_len,
  output logic [7:0]        seq_addr,
  output logic              seq_ign_nack,
  input  logic [IDX_W-1:0]  seq_tx_idx,
  output logic [7:0]        seq_tx_byte,
  input  logic              seq_rx_valid,
  input  logic [IDX_W-1:0]  seq_rx_idx,
  input  logic [7:0]        seq_rx_byte,
  input  logic              seq_done,
  input  logic              seq_nack
);
  import i2cf_pkg::*;

  localparam int unsigned RIDX_W  = $clog2(NUM_DREGS);
  localparam int unsigned SHORT_W = RIDX_W + 1;
  localparam int unsigned BYTES_MAX = NUM_DREGS * BYTES_PER_WORD;

  localparam logic [ADDR_W-1:0] A_TADDR = ADDR_W'(W_TADDR);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(W_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(W_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(W_MODE);
  localparam logic [ADDR_W-1:0] A_XFER  = ADDR_W'(W_XFER);
  localparam logic [ADDR_W-1:0] A_TX    = ADDR_W'(NUM_DREGS);
  localparam logic [ADDR_W-1:0] A_RX    = ADDR_W'(2 * NUM_DREGS);
  localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(3 * NUM_DREGS);
  localparam logic [LEN_W-1:0]  CAP_WIDE   = LEN_W'(BYTES_MAX);
  localparam logic [LEN_W-1:0]  CAP_NARROW = LEN_W'(NUM_DREGS);

  // configuration registers
  logic [7:0]       taddr_q;
  logic [LEN_W-1:0] count_q;
  i2cf_dir_e        dir_q;
  logic             irq_en_q;
  logic             wide_q;
  logic             ign_q;

  // launch / status state
  logic       busy_q, done_q, nack_q, start_q;
  logic [2:0] cond_q;

  logic [LEN_W-1:0] eff_cnt;
  logic wr_xfer, wr_tx, in_tx_win, in_rx_win;

  assign in_tx_win = (bus_addr >= A_TX) && (bus_addr < A_RX);
  assign in_rx_win = (bus_addr >= A_RX) && (bus_addr < A_END);
  assign wr_xfer   = bus_wr_en && (bus_addr == A_XFER);
  assign wr_tx     = bus_wr_en && in_tx_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      taddr_q  <= 8'd0;
      count_q  <= '0;
      dir_q    <= DIR_WRITE;
      irq_en_q <= 1'b0;
      wide_q   <= 1'b0;
      ign_q    <= 1'b0;
    end else if (bus_wr_en) begin
      unique case (bus_addr)
        A_TADDR: taddr_q <= bus_wdata[7:0];
        A_COUNT: count_q <= bus_wdata[LEN_W-1:0];
        A_CTRL: begin
          dir_q    <= i2cf_dir_e'(bus_wdata[1:0]);
          irq_en_q <= bus_wdata[CTRL_IRQEN];
        end
        A_MODE: begin
          wide_q <= bus_wdata[MODE_WIDE];
          ign_q  <= bus_wdata[MODE_IGNACK];
        end
        default: ;
      endcase
    end
  end

  // count field follows the data word size
  always_comb begin
    if (wide_q) eff_cnt = count_q;
    else        eff_cnt = {{(LEN_W-SHORT_W){1'b0}}, count_q[SHORT_W-1:0]};
  end

  always_comb begin
    if (wide_q) seq_len = (eff_cnt > CAP_WIDE)   ? CAP_WIDE   : eff_cnt;
    else        seq_len = (eff_cnt > CAP_NARROW) ? CAP_NARROW : eff_cnt;
  end

  i2cf_xfer_ctrl u_xfer (
    .clk      (clk),
    .rst      (rst),
    .wr_xfer  (wr_xfer),
    .wr_zero  (bus_wdata == 32'd0),
    .wval     (bus_wdata[6:0]),
    .seq_done (seq_done),
    .seq_nack (seq_nack),
    .ign_nack (ign_q),
    .busy_o   (busy_q),
    .done_o   (done_q),
    .nack_o   (nack_q),
    .start_o  (start_q),
    .cond_o   (cond_q)
  );

  // byte index to word/lane decode, one per sequencer byte path
  logic [RIDX_W-1:0] tx_sel, rx_sel;
  logic [1:0]        tx_lane, rx_lane;
  logic              tx_ok, rx_ok;

  i2cf_lane_map #(.NUM_DREGS(NUM_DREGS), .IDX_W(IDX_W), .RIDX_W(RIDX_W)) u_tx_map (
    .wide(wide_q), .idx(seq_tx_idx), .sel(tx_sel), .lane(tx_lane), .in_range(tx_ok)
  );

  i2cf_lane_map #(.NUM_DREGS(NUM_DREGS), .IDX_W(IDX_W), .RIDX_W(RIDX_W)) u_rx_map (
    .wide(wide_q), .idx(seq_rx_idx), .sel(rx_sel), .lane(rx_lane), .in_range(rx_ok)
  );

  logic [7:0]  tx_byte_raw;
  logic [31:0] tx_word, rx_word;

  i2cf_data_bank #(.NUM_DREGS(NUM_DREGS), .RIDX_W(RIDX_W)) u_bank (
    .clk      (clk),
    .tx_we    (wr_tx),
    .tx_wsel  (bus_addr[RIDX_W-1:0]),
    .tx_wdata (bus_wdata),
    .rx_we    (seq_rx_valid && busy_q && rx_ok),
    .rx_sel   (rx_sel),
    .rx_lane  (rx_lane),
    .rx_byte  (seq_rx_byte),
    .tx_rsel  (tx_sel),
    .tx_lane  (tx_lane),
    .rd_sel   (bus_addr[RIDX_W-1:0]),
    .tx_byte  (tx_byte_raw),
    .tx_word  (tx_word),
    .rx_word  (rx_word)
  );

  // register read path
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = 32'd0;
    if (in_rx_win) begin
      rd_mux = rx_word;
    end else if (in_tx_win) begin
      rd_mux = tx_word;
    end else begin
      unique case (bus_addr)
        A_TADDR: rd_mux[7:0] = taddr_q;
        A_COUNT: rd_mux[LEN_W-1:0] = eff_cnt;
        A_CTRL: begin
          rd_mux[1:0]       = dir_q;
          rd_mux[CTRL_IRQEN] = irq_en_q;
        end
        A_MODE: begin
          rd_mux[MODE_WIDE]   = wide_q;
          rd_mux[MODE_IGNACK] = ign_q;
        end
        A_XFER: begin
          rd_mux[XS_GO]                      = busy_q;
          rd_mux[XS_DONE]                    = done_q;
          rd_mux[XS_NACK]                    = nack_q;
          rd_mux[XS_COND_LSB +: 3]           = cond_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= 32'd0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end

  assign irq          = done_q & irq_en_q;
  assign seq_start    = start_q;
  assign seq_dir      = dir_q;
  assign seq_cond     = cond_q;
  assign seq_addr     = taddr_q;
  assign seq_ign_nack = ign_q;
  assign seq_tx_byte  = tx_ok ? tx_byte_raw : 8'h00;
endmodule

// File: rtl/i2cf_seg_front_chk.sv
module i2cf_seg_front_chk #(
  parameter int unsigned NUM_DREGS = 8,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned LEN_W     = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              seq_start,
  input logic              seq_done,
  input logic              seq_nack,
  input logic [LEN_W-1:0]  seq_len,
  input logic              busy,
  input logic              done,
  input logic              nack,
  input logic              wide,
  input logic              ign
);
  localparam logic [ADDR_W-1:0] A_XFER     = ADDR_W'(i2cf_pkg::W_XFER);
  localparam logic [LEN_W-1:0]  CAP_WIDE   = LEN_W'(NUM_DREGS * 4);
  localparam logic [LEN_W-1:0]  CAP_NARROW = LEN_W'(NUM_DREGS);

  AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (rst)
    seq_len <= (wide ? CAP_WIDE : CAP_NARROW)); // R4

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start); // R5

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> !$past(busy)); // R6

  AST_DONE_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(seq_done) && $past(busy))); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !busy); // R7

  AST_NACK_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(nack) |-> ($past(seq_nack) && !$past(ign))); // R8

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == A_XFER && bus_wdata == 32'd0) |=> (!busy && !done && !nack)); // R9
endmodule

bind i2cf_seg_front i2cf_seg_front_chk #(
  .NUM_DREGS(NUM_DREGS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .seq_start (seq_start),
  .seq_done  (seq_done),
  .seq_nack  (seq_nack),
  .seq_len   (seq_len),
  .busy      (busy_q),
  .done      (done_q),
  .nack      (nack_q),
  .wide      (wide_q),
  .ign       (ign_q)
);

// File: tb/i2cf_seg_front_bench.sv
module i2cf_seg_front_bench;
  localparam int N  = 8;
  localparam int AW = 5;
  localparam int LW = 6;
  localparam int IW = 5;
  localparam int XF = 4;
  localparam int RXB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          bus_wr_en = 0, bus_rd_en = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic          irq, seq_start, seq_ign_nack;
  logic [1:0]    seq_dir;
  logic [2:0]    seq_cond;
  logic [LW-1:0] seq_len;
  logic [7:0]    seq_addr, seq_tx_byte;
  logic [IW-1:0] seq_tx_idx = '0, seq_rx_idx = '0;
  logic          seq_rx_valid = 0, seq_done = 0, seq_nack = 0;
  logic [7:0]    seq_rx_byte = '0;

  i2cf_seg_front u_i2cf_seg_front (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .seq_start(seq_start), .seq_dir(seq_dir), .seq_cond(seq_cond),
    .seq_len(seq_len), .seq_addr(seq_addr), .seq_ign_nack(seq_ign_nack),
    .seq_tx_idx(seq_tx_idx), .seq_tx_byte(seq_tx_byte),
    .seq_rx_valid(seq_rx_valid), .seq_rx_idx(seq_rx_idx), .seq_rx_byte(seq_rx_byte),
    .seq_done(seq_done), .seq_nack(seq_nack)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd_en = 0;
    d = bus_rdata;
  endtask

  task automatic rx_push(input int idx, input logic [7:0] b);
    @(negedge clk);
    seq_rx_valid = 1; seq_rx_idx = IW'(idx); seq_rx_byte = b;
    @(negedge clk);
    seq_rx_valid = 0;
  endtask

  task automatic done_pulse(input logic nk);
    @(negedge clk);
    seq_done = 1; seq_nack = nk;
    @(negedge clk);
    seq_done = 0; seq_nack = 0;
  endtask

  function automatic logic [7:0] txb(input int i);  return 8'((i * 3 + 5) & 255); endfunction
  function automatic logic [7:0] rxc(input int i);  return 8'((i * 11 + 1) & 255); endfunction
  function automatic logic [7:0] rxd(input int i);  return 8'((i * 5 + 3) & 255); endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog R5 act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 seq_start", {31'd0, seq_start}, 32'd0);
    for (int a = 0; a <= XF; a++) begin
      rd(a, d);
      chk("R1 reg", d, 32'd0);
    end

    // count width and limiting in both modes
    for (int m = 0; m < 2; m++) begin
      wr(3, m ? 32'h40 : 32'h0);
      for (int c = 0; c < 64; c++) begin
        int msk, cap;
        msk = m ? (c & 63) : (c & 15);
        cap = m ? 32 : 8;
        wr(1, 32'(c));
        rd(1, d);
        chk("R4 count readback", d, 32'(msk));
        chk("R4 seq_len", 32'(seq_len), 32'(msk > cap ? cap : msk));
      end
    end

    // four-byte mode segment
    wr(3, 32'h40);
    wr(2, 32'h43);
    wr(0, 32'hA4);
    wr(1, 32'd32);
    for (int r = 0; r < N; r++) begin
      w = 0;
      for (int k = 0; k < 4; k++) w |= 32'(txb(4 * r + k)) << (8 * k);
      wr(8 + r, w);
    end
    wr(XF, 32'h51);
    chk("R5 start pulse", {31'd0, seq_start}, 32'd1);
    chk("R5 dir", 32'(seq_dir), 32'd3);
    chk("R5 cond", 32'(seq_cond), 32'd5);
    chk("R5 addr", 32'(seq_addr), 32'hA4);
    @(negedge clk);
    chk("R5 start one cycle", {31'd0, seq_start}, 32'd0);
    rd(XF, d);
    chk("R5 busy readback", d, 32'h51);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      seq_tx_idx = IW'(i);
      #1;
      chk("R2 tx byte", 32'(seq_tx_byte), 32'(txb(i)));
    end
    for (int i = 0; i < 32; i++) rx_push(i, rxc(i));
    wr(XF, 32'h21);
    chk("R6 no restart", {31'd0, seq_start}, 32'd0);
    rd(XF, d);
    chk("R6 reg kept", d, 32'h51);
    done_pulse(1'b1);
    chk("R7 irq on done", {31'd0, irq}, 32'd1);
    rd(XF, d);
    chk("R8 nack recorded", d, 32'h56);
    for (int r = 0; r < N; r++) begin
      w = 0;
      for (int k = 0; k < 4; k++) w |= 32'(rxc(4 * r + k)) << (8 * k);
      rd(RXB + r, d);
      chk("R10 rx wide pack", d, w);
    end
    w = 0;
    for (int k = 0; k < 4; k++) w |= 32'(rxc(k)) << (8 * k);
    wr(RXB, 32'hDEADBEEF);
    rd(RXB, d);
    chk("R11 rx write ignored", d, w);
    wr(XF, 32'h0);
    rd(XF, d);
    chk("R9 zero clears", d, 32'd0);
    chk("R9 irq low", {31'd0, irq}, 32'd0);

    // one-byte mode segment, acknowledge ignored
    wr(3, 32'h02);
    wr(2, 32'h01);
    wr(1, 32'd8);
    for (int r = 0; r < N; r++) wr(8 + r, 32'hA5A5A500 | 32'((r * 9 + 2) & 255));
    wr(XF, 32'h01);
    chk("R5 start narrow", {31'd0, seq_start}, 32'd1);
    chk("R5 dir read", 32'(seq_dir), 32'd1);
    chk("R4 len narrow", 32'(seq_len), 32'd8);
    for (int i = 0; i <= 8; i++) begin
      @(negedge clk);
      seq_tx_idx = IW'(i);
      #1;
      chk("R3 tx byte", 32'(seq_tx_byte), (i < 8) ? 32'((i * 9 + 2) & 255) : 32'd0);
    end
    for (int i = 0; i < 16; i++) rx_push(i, rxd(i));
    done_pulse(1'b1);
    rd(XF, d);
    chk("R8 nack ignored", d, 32'h02);
    chk("R7 irq disabled", {31'd0, irq}, 32'd0);
    for (int r = 0; r < N; r++) begin
      w = {rxc(4 * r + 3), rxc(4 * r + 2), rxc(4 * r + 1), rxd(r)};
      rd(RXB + r, d);
      chk("R10 rx narrow pack", d, w);
    end

    // completion and abort in the same cycle
    wr(3, 32'h40);
    wr(2, 32'h40);
    wr(1, 32'd4);
    wr(XF, 32'h01);
    @(negedge clk);
    bus_wr_en = 1; bus_addr = AW'(XF); bus_wdata = 32'd0;
    seq_done = 1; seq_nack = 1;
    @(negedge clk);
    bus_wr_en = 0; seq_done = 0; seq_nack = 0;
    rd(XF, d);
    chk("R9 abort beats done", d, 32'd0);
    chk("R9 irq after collision", {31'd0, irq}, 32'd0);
    done_pulse(1'b0);
    rd(XF, d);
    chk("R7 done while idle", d, 32'd0);
    rx_push(0, 8'hEE);
    rd(RXB, d);
    chk("R10 rx idle dropped", d, {rxc(3), rxc(2), rxc(1), rxd(0)});

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule